// File: doc/BRIEF.md
# GMSK Burst Start-up Sequencer

This block orders the events that open a GMSK transmit burst. Time is counted in quarter-symbol ticks (qst) supplied by a one-cycle `qst_tick` strobe. A burst-start strobe launches a timeline. The modulator is started at once. Its clock is realigned after a programmable guard delay, so that any disturbance falls while output power is still at its floor. Transmit-enable asserts a programmable advance after the modulator start. The power-amplifier enable follows after a programmable gap. A one-cycle top-of-ramp flag marks the end of a ramp of selectable length. Overall latency is the guard delay plus the fixed 12 qst of the modulation path. Setting the guard delay to 6 matches a path with 18 qst latency. Serial operation uses an advance of 66 qst plus the guard delay.

After the clock realignment, a symbol boundary occurs every 4 qst. The first boundary is blanked and raises no request. A small differential encoder turns each requested data bit into the XOR of that bit and the previous one. Its history register is seeded to 1 at a symbol boundary chosen by the guard-symbol count; a count of 1 puts the seed on the blanked boundary. When the bit stream is already differentially coded upstream, a bypass input passes bits through unchanged. A stop input, or the synchronous reset, ends the burst and returns everything to idle.

Top module: `gbs_startup_seq`

## Requirements
- R1: A `burst_start` seen at a clock edge while idle (and with `burst_stop` low) raises `mod_start` for exactly one cycle after that edge. This edge is tick 0 of the burst.
- R2: `mod_clk_rst` pulses for one cycle at the edge of tick `guard_dly` (guard_dly >= 1).
- R3: `tx_en` rises at the edge of tick `mod_adv` (mod_adv >= 1) and stays high until `burst_stop` or reset.
- R4: `pa_en` rises `pa_dly` ticks after `tx_en` rises, in the same edge when `pa_dly` is 0, and is never high without `tx_en`.
- R5: `top_ramp` pulses for one cycle `L` ticks after `pa_en` rises, where `ramp_sel` 0 gives L=8, 1 gives L=13, and 2 or 3 give L=16.
- R6: Symbol boundaries fall at ticks `guard_dly + 4k` for k >= 1. The boundary with k=1 is blanked. `sym_req` pulses for one cycle at every later boundary.
- R7: With `enc_bypass` low, at each `sym_req` the output `enc_bit` equals `sym_bit` (sampled at that edge) XOR the history bit. The history bit then takes `sym_bit`. It is cleared to 0 at burst start and set to 1 at tick `guard_dly + 4*guard_cnt`. If that seed tick is also a request, the request is coded against 1.
- R8: With `enc_bypass` high, `enc_bit` equals `sym_bit` at each `sym_req`, whatever `guard_cnt` is.
- R9: A `burst_start` arriving while a burst is active is ignored: no `mod_start`, and the timeline is unchanged.
- R10: `burst_stop` or `rst` clears all outputs at the next edge and returns the block to idle, ready for a new burst.
- R11: Apart from `mod_start`, every output event occurs only at an edge where `qst_tick` is high. Gaps between ticks stretch the timeline without changing it in tick units.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| qst_tick | input | 1 | Quarter-symbol tick strobe |
| burst_start | input | 1 | Burst launch strobe |
| burst_stop | input | 1 | Ends the burst, returns to idle |
| guard_dly | input | DW | Guard delay in qst |
| mod_adv | input | DW | Modulator-start to transmit-enable distance in qst |
| guard_cnt | input | GCW | Symbol boundary at which the encoder is seeded |
| pa_dly | input | DW | Transmit-enable to PA-enable distance in qst |
| ramp_sel | input | 2 | Ramp length select (8/13/16/16 qst) |
| enc_bypass | input | 1 | Pass bits without differential coding |
| sym_bit | input | 1 | Data bit for the pending symbol request |
| mod_start | output | 1 | Modulator start pulse |
| mod_clk_rst | output | 1 | Modulator clock realignment pulse |
| tx_en | output | 1 | Transmit enable |
| pa_en | output | 1 | Power-amplifier enable |
| top_ramp | output | 1 | Top-of-ramp pulse |
| sym_req | output | 1 | Symbol request / encoded bit valid |
| enc_bit | output | 1 | Encoded symbol bit |

## Verification
The assertions assume that `guard_dly` and `mod_adv` are at least 1 and that all configuration inputs hold steady from burst start until stop. They also assume that `qst_tick` is a clean strobe. The stimulus loads each configuration before raising `burst_start` and does not touch it until after the stop. Tick spacing varies between bursts: one tick every clock, every second clock, or every third clock. This lets the tick-unit timeline be compared regardless of spacing. Some bursts place the encoder seed on the blanked boundary, some on a live request, and one applies the seed at the realignment tick.

// File: rtl/gbs_pkg.sv
package gbs_pkg;
  localparam int SYM_QST    = 4;
  localparam int RAMP_SHORT = 8;
  localparam int RAMP_MID   = 13;
  localparam int RAMP_LONG  = 16;
  localparam int RLW        = 5;

  function automatic logic [RLW-1:0] ramp_qst(input logic [1:0] sel);
    case (sel)
      2'd0:    ramp_qst = RLW'(RAMP_SHORT);
      2'd1:    ramp_qst = RLW'(RAMP_MID);
      default: ramp_qst = RLW'(RAMP_LONG);
    endcase
  endfunction
endpackage

// File: rtl/gbs_timer.sv
module gbs_timer #(
  parameter int DW  = 8,
  parameter int GCW = 4,
  parameter int TW  = DW + 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic           start,
  input  logic           stop,
  input  logic [DW-1:0]  guard_dly,
  input  logic [DW-1:0]  mod_adv,
  input  logic [DW-1:0]  pa_dly,
  input  logic [GCW-1:0] guard_cnt,
  input  logic [1:0]     ramp_sel,
  output logic           busy,
  output logic           start_acc,
  output logic           evt_clk_rst,
  output logic           evt_tx,
  output logic           evt_pa,
  output logic           evt_top,
  output logic           evt_seed
);
  import gbs_pkg::*;
  localparam int NW = TW + 1;

  logic [TW-1:0] tcnt;
  logic [NW-1:0] nxt, t_clk, t_tx, t_pa, t_top, t_seed;
  logic          step;

  assign start_acc = start && !busy && !stop;
  assign step      = busy && tick && !stop && (tcnt != '1);
  assign nxt       = NW'(tcnt) + NW'(1);

  always_comb begin
    t_clk  = NW'(guard_dly);
    t_tx   = NW'(mod_adv);
    t_pa   = t_tx + NW'(pa_dly);
    t_top  = t_pa + NW'(ramp_qst(ramp_sel));
    t_seed = t_clk + (NW'(guard_cnt) << $clog2(SYM_QST));
  end

  assign evt_clk_rst = step && (nxt == t_clk);
  assign evt_tx      = step && (nxt == t_tx);
  assign evt_pa      = step && (nxt == t_pa);
  assign evt_top     = step && (nxt == t_top);
  assign evt_seed    = step && (nxt == t_seed);

  always_ff @(posedge clk) begin
    if (rst || stop) begin
      busy <= 1'b0;
      tcnt <= '0;
    end else if (start_acc) begin
      busy <= 1'b1;
      tcnt <= '0;
    end else if (step) begin
      tcnt <= nxt[TW-1:0];
    end
  end
endmodule

// File: rtl/gbs_sym_gen.sv
module gbs_sym_gen #(
  parameter int SYM_QST = 4,
  parameter int PW      = $clog2(SYM_QST)
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic clear,
  input  logic realign,
  output logic req_now
);
  logic [PW-1:0] phase;
  logic          armed;
  logic          blank;
  logic          boundary;

  assign boundary = armed && tick && !realign && (phase == PW'(SYM_QST - 1));
  assign req_now  = boundary && !blank;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      armed <= 1'b0;
      blank <= 1'b0;
      phase <= '0;
    end else if (realign) begin
      armed <= 1'b1;
      blank <= 1'b1;
      phase <= '0;
    end else if (armed && tick) begin
      phase <= (phase == PW'(SYM_QST - 1)) ? '0 : phase + PW'(1);
      if (boundary) blank <= 1'b0;
    end
  end
endmodule

// File: rtl/gbs_diff_enc.sv
module gbs_diff_enc (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic seed,
  input  logic req,
  input  logic bypass,
  input  logic bit_in,
  output logic enc_bit
);
  logic hist;
  logic hist_eff;

  assign hist_eff = seed ? 1'b1 : hist;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      hist    <= 1'b0;
      enc_bit <= 1'b0;
    end else if (req) begin
      enc_bit <= bypass ? bit_in : (bit_in ^ hist_eff);
      hist    <= bit_in;
    end else if (seed) begin
      hist <= 1'b1;
    end
  end
endmodule

// File: rtl/gbs_startup_seq.sv
module gbs_startup_seq #(
  parameter int DW  = 8,
  parameter int GCW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           qst_tick,
  input  logic           burst_start,
  input  logic           burst_stop,
  input  logic [DW-1:0]  guard_dly,
  input  logic [DW-1:0]  mod_adv,
  input  logic [GCW-1:0] guard_cnt,
  input  logic [DW-1:0]  pa_dly,
  input  logic [1:0]     ramp_sel,
  input  logic           enc_bypass,
  input  logic           sym_bit,
  output logic           mod_start,
  output logic           mod_clk_rst,
  output logic           tx_en,
  output logic           pa_en,
  output logic           top_ramp,
  output logic           sym_req,
  output logic           enc_bit
);
  import gbs_pkg::*;
  localparam int TW = DW + 2;

  logic busy, start_acc, evt_clk_rst, evt_tx, evt_pa, evt_top, evt_seed;
  logic req_now, clr;

  assign clr = start_acc || burst_stop;

  gbs_timer #(.DW(DW), .GCW(GCW), .TW(TW)) u_timer (
    .clk(clk), .rst(rst), .tick(qst_tick), .start(burst_start), .stop(burst_stop),
    .guard_dly(guard_dly), .mod_adv(mod_adv), .pa_dly(pa_dly),
    .guard_cnt(guard_cnt), .ramp_sel(ramp_sel),
    .busy(busy), .start_acc(start_acc), .evt_clk_rst(evt_clk_rst),
    .evt_tx(evt_tx), .evt_pa(evt_pa), .evt_top(evt_top), .evt_seed(evt_seed)
  );

  gbs_sym_gen #(.SYM_QST(SYM_QST)) u_sym (
    .clk(clk), .rst(rst), .tick(qst_tick), .clear(clr),
    .realign(evt_clk_rst), .req_now(req_now)
  );

  gbs_diff_enc u_enc (
    .clk(clk), .rst(rst), .clear(clr), .seed(evt_seed), .req(req_now),
    .bypass(enc_bypass), .bit_in(sym_bit), .enc_bit(enc_bit)
  );

  always_ff @(posedge clk) begin
    if (rst || burst_stop) begin
      mod_start   <= 1'b0;
      mod_clk_rst <= 1'b0;
      tx_en       <= 1'b0;
      pa_en       <= 1'b0;
      top_ramp    <= 1'b0;
      sym_req     <= 1'b0;
    end else begin
      mod_start   <= start_acc;
      mod_clk_rst <= evt_clk_rst;
      tx_en       <= tx_en || evt_tx;
      pa_en       <= pa_en || evt_pa;
      top_ramp    <= evt_top;
      sym_req     <= req_now;
    end
  end
endmodule

// File: rtl/gbs_startup_seq_chk.sv
module gbs_startup_seq_chk (
  input logic clk,
  input logic rst,
  input logic qst_tick,
  input logic burst_stop,
  input logic busy,
  input logic mod_start,
  input logic mod_clk_rst,
  input logic tx_en,
  input logic pa_en,
  input logic top_ramp,
  input logic sym_req
);
  // R1
  mod_start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mod_start |=> !mod_start);
  // R9
  start_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    mod_start |-> !$past(busy));
  // R3
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_en && !burst_stop) |=> tx_en);
  // R4
  pa_needs_tx_chk: assert property (@(posedge clk) disable iff (rst)
    pa_en |-> tx_en);
  // R5
  top_with_pa_chk: assert property (@(posedge clk) disable iff (rst)
    top_ramp |-> pa_en);
  // R10
  stop_clears_chk: assert property (@(posedge clk) disable iff (rst)
    burst_stop |=> (!tx_en && !pa_en && !sym_req && !top_ramp));
  // R11
  sym_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (sym_req || mod_clk_rst) |-> $past(qst_tick));
endmodule

bind gbs_startup_seq gbs_startup_seq_chk u_chk (
  .clk(clk), .rst(rst), .qst_tick(qst_tick), .burst_stop(burst_stop),
  .busy(busy), .mod_start(mod_start), .mod_clk_rst(mod_clk_rst),
  .tx_en(tx_en), .pa_en(pa_en), .top_ramp(top_ramp), .sym_req(sym_req)
);

// File: tb/tb_gbs_startup_seq.sv
`timescale 1ns/1ps
module tb_gbs_startup_seq;
  logic clk = 1'b0, rst = 1'b1, qst_tick = 1'b0, burst_start = 1'b0, burst_stop = 1'b0;
  logic [7:0] guard_dly = 8'd1, mod_adv = 8'd1, pa_dly = 8'd0;
  logic [3:0] guard_cnt = 4'd0;
  logic [1:0] ramp_sel = 2'd0;
  logic enc_bypass = 1'b0, sym_bit = 1'b0;
  logic mod_start, mod_clk_rst, tx_en, pa_en, top_ramp, sym_req, enc_bit;

  gbs_startup_seq dut (
    .clk(clk), .rst(rst), .qst_tick(qst_tick), .burst_start(burst_start),
    .burst_stop(burst_stop), .guard_dly(guard_dly), .mod_adv(mod_adv),
    .guard_cnt(guard_cnt), .pa_dly(pa_dly), .ramp_sel(ramp_sel),
    .enc_bypass(enc_bypass), .sym_bit(sym_bit), .mod_start(mod_start),
    .mod_clk_rst(mod_clk_rst), .tx_en(tx_en), .pa_en(pa_en),
    .top_ramp(top_ramp), .sym_req(sym_req), .enc_bit(enc_bit)
  );

  always #10 clk = ~clk;

  typedef struct { int n; int kind; bit val; } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0, mon_n = 0, req_seen = 0;
  bit mon_on = 0, starting = 0, tx_q = 0, pa_q = 0;

  function automatic bit pbit(int k, int salt);
    return (((k * 3 + salt) % 5) < 2);
  endfunction

  function automatic string tag(int kind);
    case (kind)
      0: return "R1"; 1: return "R2"; 2: return "R3";
      3: return "R4"; 4: return "R5"; default: return "R6";
    endcase
  endfunction

  task automatic push(int n, int kind, bit val);
    exp_t it;
    it.n = n; it.kind = kind; it.val = val;
    q.push_back(it);
  endtask

  // Monitor: pops expected events and compares with observed outputs
  always @(posedge clk) begin
    bit te;
    logic [5:0] obs, expm;
    bit ev;
    exp_t it;
    te = qst_tick;
    #2;
    if (mon_on) begin
      if (starting) begin mon_n = 0; starting = 0; end
      else if (te) mon_n++;
      obs = {sym_req, top_ramp, pa_en && !pa_q, tx_en && !tx_q, mod_clk_rst, mod_start};
      expm = '0; ev = 0;
      while (q.size() > 0 && q[0].n == mon_n) begin
        it = q.pop_front();
        expm[it.kind] = 1'b1;
        if (it.kind == 5) ev = it.val;
      end
      if (obs != 0 || expm != 0) begin
        checks++;
        if (obs != expm) begin
          string t;
          t = "R11";
          for (int i = 5; i >= 0; i--) if (obs[i] != expm[i]) t = tag(i);
          if (obs[0] && !expm[0]) t = "R9";
          fails++;
          $display("FAIL %s tick=%0d events actual=%b expected=%b", t, mon_n, obs, expm);
        end
      end
      if (obs[5] && expm[5]) begin
        checks++;
        if (enc_bit !== ev) begin
          fails++;
          $display("FAIL %s tick=%0d enc_bit actual=%b expected=%b",
                   enc_bypass ? "R8" : "R7", mon_n, enc_bit, ev);
        end
      end
      if (sym_req) req_seen++;
    end
    tx_q = tx_en; pa_q = pa_en;
  end

  task automatic check_idle(string t);
    checks++;
    if ({mod_start, mod_clk_rst, tx_en, pa_en, top_ramp, sym_req, enc_bit} !== 7'b0) begin
      fails++;
      $display("FAIL %s outputs actual=%b expected=0000000", t,
               {mod_start, mod_clk_rst, tx_en, pa_en, top_ramp, sym_req, enc_bit});
    end
  endtask

  // Driver: builds the expected timeline, then plays the burst
  task automatic run_burst(int g, int a, int gc, int p, int rs, bit byp,
                           int salt, int gap, int dup);
    int rl, nend, seedn, k, cyc;
    bit prev, pe, b;
    rl = (rs == 0) ? 8 : (rs == 1) ? 13 : 16;
    nend = a + p + rl + 6;
    seedn = g + 4 * gc;
    prev = 0; k = 0;
    q.delete();
    for (int n = 0; n <= nend; n++) begin
      if (n == 0) push(n, 0, 0);
      if (n == g) push(n, 1, 0);
      if (n == a) push(n, 2, 0);
      if (n == a + p) push(n, 3, 0);
      if (n == a + p + rl) push(n, 4, 0);
      pe = (n == seedn) ? 1'b1 : prev;
      if (n >= g + 8 && ((n - g) % 4) == 0) begin
        b = pbit(k, salt); k++;
        push(n, 5, byp ? b : (b ^ pe));
        prev = b;
      end else if (n == seedn) prev = 1'b1;
    end
    @(negedge clk);
    guard_dly = 8'(g); mod_adv = 8'(a); guard_cnt = 4'(gc); pa_dly = 8'(p);
    ramp_sel = 2'(rs); enc_bypass = byp;
    req_seen = 0; sym_bit = pbit(0, salt);
    burst_start = 1; qst_tick = 1; starting = 1; mon_on = 1; cyc = 0;
    while (1) begin
      @(negedge clk);
      if (mon_n >= nend && !starting) break;
      cyc++;
      burst_start = (cyc == dup);
      qst_tick = ((cyc % gap) == 0);
      sym_bit = pbit(req_seen, salt);
    end
    burst_start = 0; burst_stop = 1; qst_tick = 1; mon_on = 0;
    @(negedge clk);
    burst_stop = 0; qst_tick = 0;
    check_idle("R10 after stop");
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R6 missing events actual=%0d expected=0", q.size());
    end
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R10 reset state");
    rst = 0;
    @(negedge clk);
    check_idle("R10 idle");
    // R1 R2 R3 R4 R5 R6 R7: serial-style advance, seed on blanked boundary
    run_burst(6, 72, 1, 2, 0, 0, 1, 1, -1);
    // R9 R11: duplicate start, sparse ticks, seed coincides with request
    run_burst(3, 20, 3, 0, 1, 0, 2, 3, 30);
    // R8: bypass, seed at realignment, tx before symbols
    run_burst(1, 5, 0, 5, 2, 1, 3, 1, -1);
    // R5 R7 R11: ramp_sel 3, ticks every second clock
    run_burst(10, 12, 2, 3, 3, 0, 4, 2, -1);
    // R10: reset in the middle of a burst
    @(negedge clk);
    guard_dly = 8'd2; mod_adv = 8'd4; pa_dly = 8'd1;
    burst_start = 1; qst_tick = 1;
    @(negedge clk);
    burst_start = 0;
    repeat (12) @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0; qst_tick = 0;
    check_idle("R10 after mid-burst reset");
    run_burst(2, 4, 1, 1, 0, 0, 5, 1, -1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule